// File: doc/BRIEF.md
# Multiplexed-Address Byte Grid Memory

This block models a small dynamic memory chip of sixteen byte-wide cells, arranged as four rows of four columns. The address bus is only two bits wide, so each access takes two phases. A row strobe latches the pins as a row number and copies that whole row into an internal line register, called the row buffer. A column strobe then latches the pins as a column number and reads or writes one byte of the buffer. Writes change only the buffer. The modified line is copied back into the array when the row is closed: when another row strobe arrives, or when refresh takes over.

The stored lines decay. Once a set number of cycles has passed since a line was last written into the array, its contents read as zero. A built-in refresh engine raises a request at a fixed interval and serves the rows in round-robin order. Each service reads a row and writes it back, which restarts that row's retention time. Refresh waits while a column transfer is in flight. If a row was open when refresh began, that row is written back and reopened afterwards, so the controller still sees it open. While refresh is pending or running, and during a column transfer, `busy_o` is high and strobes are discarded.

The controller has five states. IDLE means no row is open. OPEN means a row is held in the buffer. XFER is the one-cycle column transfer. RFSH is the refresh write-back of one row. RESTORE reloads the row that was open before refresh began.

The transitions are:
- IDLE to OPEN on a row strobe.
- IDLE to RFSH when refresh is pending.
- OPEN to OPEN on a row strobe, which closes the current row and opens the new one.
- OPEN to XFER on a column strobe.
- OPEN to RFSH when refresh is pending.
- XFER to OPEN unconditionally.
- RFSH to RESTORE if a row had been open, otherwise RFSH to IDLE.
- RESTORE to OPEN.

A column strobe in IDLE leaves the state unchanged and pulses the error flag.

Top module: `dram_grid`

## Requirements
- R1: After reset, `rvalid_o`, `err_o` and `busy_o` are 0, `rdata_o` is 0, and every cell holds 0.
- R2: A read column strobe on an open row returns the byte at (open row, `addr_i` column) on `rdata_o`. A one-cycle `rvalid_o` pulse follows the clock edge after the one that sampled the strobe.
- R3: A write column strobe (`we_i`=1) stores `wdata_i` in the buffer. A later read of that column in the same open row returns the new byte.
- R4: Bytes written to a row survive closing the row with a strobe to another row and reopening it later.
- R5: A row strobe to the row that is already open keeps any bytes written to it, and a row that is not open never holds unsaved data.
- R6: A column strobe while no row has been opened since reset is ignored: no `rvalid_o`, and `err_o` pulses high for exactly one cycle.
- R7: `rdata_o` keeps its value from one read completion to the next. Writes do not change it.
- R8: Strobes sampled while `busy_o` is 1 have no effect. A row strobe during a column transfer leaves the previously opened row open.
- R9: With refresh active, `busy_o` rises periodically, an open row stays open across refresh, and stored data survives waits many times longer than the retention time.
- R10: With refresh effectively disabled, a row not written back into the array for longer than the retention time reads as all zero.
- R11: The cycle after a column strobe is accepted, `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Shared row/column address pins |
| row_stb_i | input | 1 | Row strobe: latch `addr_i` as row and open it |
| col_stb_i | input | 1 | Column strobe: latch `addr_i` as column and transfer |
| we_i | input | 1 | Write select, sampled with the column strobe |
| wdata_i | input | 8 | Write byte, sampled with the column strobe |
| rdata_o | output | 8 | Read byte, held between reads |
| rvalid_o | output | 1 | One-cycle pulse when `rdata_o` is updated |
| busy_o | output | 1 | Strobes are discarded while high |
| err_o | output | 1 | One-cycle pulse for a column strobe with no open row |

## Verification
The write-back path and the forwarding path only go wrong silently while a row is open. A faulty dirty flag or a faulty write-back only shows up when the row is closed and opened again, so the bench always reopens rows before comparing their data. A wrong retention or refresh pointer shows up only after hundreds of cycles, as bytes read back as zero, so the bench holds a long idle stretch. A state machine stuck in XFER or RFSH shows up immediately, because `busy_o` stays high and the expected read pulse never arrives.

// File: rtl/dgrid_pkg.sv
package dgrid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_XFER,
        ST_RFSH,
        ST_RESTORE
    } dg_state_e;

endpackage

// File: rtl/dgrid_array.sv
module dgrid_array #(
    parameter int ROWS       = 4,
    parameter int ROW_W      = 32,
    parameter int RETAIN_CYC = 1024,
    parameter int RA_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RA_W-1:0]  rd_row_i,
    output logic [ROW_W-1:0] rd_data_o,
    input  logic             wr_en_i,
    input  logic [RA_W-1:0]  wr_row_i,
    input  logic [ROW_W-1:0] wr_data_i
);
    localparam int AGE_W = $clog2(RETAIN_CYC + 1);

    logic [ROW_W-1:0] line_q [ROWS];
    logic [AGE_W-1:0] age_q  [ROWS];

    // Each line ages every cycle; a store restarts it, expiry wipes it.
    for (genvar r = 0; r < ROWS; r++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_q[r] <= '0;
                age_q[r]  <= '0;
            end else if (wr_en_i && (wr_row_i == RA_W'(r))) begin
                line_q[r] <= wr_data_i;
                age_q[r]  <= '0;
            end else if (age_q[r] == AGE_W'(RETAIN_CYC)) begin
                line_q[r] <= '0;
            end else begin
                age_q[r]  <= age_q[r] + 1'b1;
            end
        end
    end

    assign rd_data_o = line_q[rd_row_i];

endmodule

// File: rtl/dgrid_refresh.sv
module dgrid_refresh #(
    parameter int ROWS     = 4,
    parameter int INTERVAL = 64,
    parameter int RA_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grant_i,
    output logic            pend_o,
    output logic [RA_W-1:0] row_o
);
    localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [CNT_W-1:0] tick_q;
    logic             wrap;

    assign wrap = (tick_q == CNT_W'(INTERVAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (wrap) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
        end else if (wrap) begin
            pend_o <= 1'b1;
        end else if (grant_i) begin
            pend_o <= 1'b0;
        end
    end

    // Round-robin pointer moves on each serviced request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_o <= '0;
        end else if (grant_i) begin
            row_o <= (row_o == RA_W'(ROWS - 1)) ? '0 : row_o + 1'b1;
        end
    end

endmodule

// File: rtl/dgrid_ctrl.sv
module dgrid_ctrl
    import dgrid_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      row_stb_i,
    input  logic      col_stb_i,
    input  logic      ref_pend_i,
    input  logic      dirty_i,
    output dg_state_e st_o,
    output logic      busy_o,
    output logic      act_o,
    output logic      col_lat_o,
    output logic      close_wb_o,
    output logic      xfer_o,
    output logic      ref_wr_o,
    output logic      ref_grant_o,
    output logic      restore_o,
    output logic      err_o
);
    dg_state_e st_q, st_d;
    logic      was_open_q;
    logic      err_set;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            was_open_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if ((st_q != ST_RFSH) && (st_d == ST_RFSH)) begin
                was_open_q <= (st_q == ST_OPEN);
            end
        end
    end

    // Next state and control strobes.
    always_comb begin
        st_d        = st_q;
        act_o       = 1'b0;
        col_lat_o   = 1'b0;
        close_wb_o  = 1'b0;
        xfer_o      = 1'b0;
        ref_wr_o    = 1'b0;
        ref_grant_o = 1'b0;
        restore_o   = 1'b0;
        err_set     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (ref_pend_i) begin
                    st_d = ST_RFSH;
                end else if (row_stb_i) begin
                    act_o = 1'b1;
                    st_d  = ST_OPEN;
                end else if (col_stb_i) begin
                    err_set = 1'b1;
                end
            end
            ST_OPEN: begin
                if (ref_pend_i) begin
                    close_wb_o = dirty_i;
                    st_d       = ST_RFSH;
                end else if (row_stb_i) begin
                    close_wb_o = dirty_i;
                    act_o      = 1'b1;
                end else if (col_stb_i) begin
                    col_lat_o = 1'b1;
                    st_d      = ST_XFER;
                end
            end
            ST_XFER: begin
                xfer_o = 1'b1;
                st_d   = ST_OPEN;
            end
            ST_RFSH: begin
                ref_wr_o    = 1'b1;
                ref_grant_o = 1'b1;
                st_d        = was_open_q ? ST_RESTORE : ST_IDLE;
            end
            ST_RESTORE: begin
                restore_o = 1'b1;
                st_d      = ST_OPEN;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else begin
            err_o <= err_set;
        end
    end

    assign st_o   = st_q;
    assign busy_o = ref_pend_i || (st_q == ST_XFER) || (st_q == ST_RFSH)
                    || (st_q == ST_RESTORE);

endmodule

// File: rtl/dgrid_rowbuf.sv
module dgrid_rowbuf #(
    parameter int COLS   = 4,
    parameter int CELL_W = 8,
    parameter int RA_W   = 2,
    parameter int CA_W   = 2,
    parameter int PIN_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PIN_W-1:0]       addr_i,
    input  logic                   act_i,
    input  logic                   restore_i,
    input  logic                   close_wb_i,
    input  logic                   col_lat_i,
    input  logic                   xfer_i,
    input  logic                   we_i,
    input  logic [CELL_W-1:0]      wdata_i,
    input  logic [COLS*CELL_W-1:0] load_i,
    output logic [COLS*CELL_W-1:0] line_o,
    output logic [RA_W-1:0]        row_o,
    output logic                   dirty_o,
    output logic [CELL_W-1:0]      rdata_o,
    output logic                   rvalid_o
);
    logic [CELL_W-1:0] cell_q [COLS];
    logic [CA_W-1:0]   col_q;
    logic              we_q;
    logic [CELL_W-1:0] wd_q;
    logic              fwd;
    logic              load_en;

    // Reopening the same modified row keeps the buffer instead of the array.
    assign fwd     = (addr_i[RA_W-1:0] == row_o) && dirty_o;
    assign load_en = (act_i && !fwd) || restore_i;

    for (genvar c = 0; c < COLS; c++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q[c] <= '0;
            end else if (load_en) begin
                cell_q[c] <= load_i[c*CELL_W +: CELL_W];
            end else if (xfer_i && we_q && (col_q == CA_W'(c))) begin
                cell_q[c] <= wd_q;
            end
        end
        assign line_o[c*CELL_W +: CELL_W] = cell_q[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_o <= '0;
        end else if (act_i) begin
            row_o <= addr_i[RA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dirty_o <= 1'b0;
        end else if (act_i || close_wb_i || restore_i) begin
            dirty_o <= 1'b0;
        end else if (xfer_i && we_q) begin
            dirty_o <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            we_q  <= 1'b0;
            wd_q  <= '0;
        end else if (col_lat_i) begin
            col_q <= addr_i[CA_W-1:0];
            we_q  <= we_i;
            wd_q  <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= xfer_i && !we_q;
            if (xfer_i && !we_q) begin
                rdata_o <= cell_q[col_q];
            end
        end
    end

endmodule

// File: rtl/dram_grid.sv
module dram_grid
    import dgrid_pkg::*;
#(
    parameter int ROWS         = 4,
    parameter int COLS         = 4,
    parameter int CELL_W       = 8,
    parameter int REF_INTERVAL = 64,
    parameter int RETAIN_CYC   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_i,
    input  logic              row_stb_i,
    input  logic              col_stb_i,
    input  logic              we_i,
    input  logic [CELL_W-1:0] wdata_i,
    output logic [CELL_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              busy_o,
    output logic              err_o
);
    localparam int RA_W  = $clog2(ROWS);
    localparam int CA_W  = $clog2(COLS);
    localparam int ROW_W = COLS * CELL_W;

    dg_state_e        st;
    logic             dirty;
    logic             act, col_lat, close_wb, xfer, ref_wr, ref_grant, restore;
    logic             ref_pend;
    logic [RA_W-1:0]  ref_row, open_row, rd_row, wr_row;
    logic [ROW_W-1:0] rd_line, buf_line, wr_line;
    logic             wr_en;

    dgrid_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_stb_i   (row_stb_i),
        .col_stb_i   (col_stb_i),
        .ref_pend_i  (ref_pend),
        .dirty_i     (dirty),
        .st_o        (st),
        .busy_o      (busy_o),
        .act_o       (act),
        .col_lat_o   (col_lat),
        .close_wb_o  (close_wb),
        .xfer_o      (xfer),
        .ref_wr_o    (ref_wr),
        .ref_grant_o (ref_grant),
        .restore_o   (restore),
        .err_o       (err_o)
    );

    dgrid_refresh #(
        .ROWS     (ROWS),
        .INTERVAL (REF_INTERVAL),
        .RA_W     (RA_W)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_i (ref_grant),
        .pend_o  (ref_pend),
        .row_o   (ref_row)
    );

    dgrid_rowbuf #(
        .COLS   (COLS),
        .CELL_W (CELL_W),
        .RA_W   (RA_W),
        .CA_W   (CA_W),
        .PIN_W  (2)
    ) u_rowbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .act_i      (act),
        .restore_i  (restore),
        .close_wb_i (close_wb),
        .col_lat_i  (col_lat),
        .xfer_i     (xfer),
        .we_i       (we_i),
        .wdata_i    (wdata_i),
        .load_i     (rd_line),
        .line_o     (buf_line),
        .row_o      (open_row),
        .dirty_o    (dirty),
        .rdata_o    (rdata_o),
        .rvalid_o   (rvalid_o)
    );

    // Array port steering: refresh and restore own the read port in their states.
    always_comb begin
        unique case (st)
            ST_RFSH:    rd_row = ref_row;
            ST_RESTORE: rd_row = open_row;
            default:    rd_row = addr_i[RA_W-1:0];
        endcase
    end

    assign wr_en   = close_wb || ref_wr;
    assign wr_row  = ref_wr ? ref_row : open_row;
    assign wr_line = ref_wr ? rd_line : buf_line;

    dgrid_array #(
        .ROWS       (ROWS),
        .ROW_W      (ROW_W),
        .RETAIN_CYC (RETAIN_CYC),
        .RA_W       (RA_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_row_i  (rd_row),
        .rd_data_o (rd_line),
        .wr_en_i   (wr_en),
        .wr_row_i  (wr_row),
        .wr_data_i (wr_line)
    );

endmodule

// File: rtl/dgrid_chk.sv
module dgrid_chk
    import dgrid_pkg::*;
#(
    parameter int CELL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              row_stb_i,
    input logic              col_stb_i,
    input logic              busy_o,
    input logic              rvalid_o,
    input logic              err_o,
    input logic [CELL_W-1:0] rdata_o,
    input dg_state_e         st,
    input logic              dirty
);
    a_r2_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> !rvalid_o);

    a_r2_valid_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> $past(st == ST_XFER));

    a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    a_r6_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !rvalid_o);

    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> $stable(rdata_o));

    a_r5_closed_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !dirty);

    a_r11_busy_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPEN && col_stb_i && !row_stb_i && !busy_o) |=> busy_o);

endmodule

bind dram_grid dgrid_chk #(.CELL_W(CELL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_stb_i (row_stb_i),
    .col_stb_i (col_stb_i),
    .busy_o    (busy_o),
    .rvalid_o  (rvalid_o),
    .err_o     (err_o),
    .rdata_o   (rdata_o),
    .st        (st),
    .dirty     (dirty)
);

// File: tb/dram_grid_bench.sv
module dram_grid_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       row_stb = 1'b0, col_stb = 1'b0, we = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] rdata;
    logic       rvalid, busy, err;

    logic [1:0] l_addr = '0;
    logic       l_row = 1'b0, l_col = 1'b0, l_we = 1'b0;
    logic [7:0] l_wd = '0;
    logic [7:0] l_rdata;
    logic       l_rvalid, l_busy, l_err;

    int errors = 0;
    int checks = 0;
    int open_r = 0;
    logic [7:0] model [16];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    dram_grid #(.REF_INTERVAL(40), .RETAIN_CYC(300)) u_dram_grid (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .row_stb_i(row_stb),
        .col_stb_i(col_stb), .we_i(we), .wdata_i(wd), .rdata_o(rdata),
        .rvalid_o(rvalid), .busy_o(busy), .err_o(err));

    dram_grid #(.REF_INTERVAL(1000000), .RETAIN_CYC(300)) u_dram_grid_leak (
        .clk(clk), .rst_n(rst_n), .addr_i(l_addr), .row_stb_i(l_row),
        .col_stb_i(l_col), .we_i(l_we), .wdata_i(l_wd), .rdata_o(l_rdata),
        .rvalid_o(l_rvalid), .busy_o(l_busy), .err_o(l_err));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every read pulse is matched against the scoreboard queue.
    always @(negedge clk) begin
        logic [7:0] e;
        string      t;
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected rvalid", rdata, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata === e, t, rdata, e);
            end
        end
    end

    task automatic do_row(input int r);
        @(negedge clk);
        while (busy) @(negedge clk);
        addr = 2'(r); row_stb = 1'b1;
        @(negedge clk);
        row_stb = 1'b0;
        open_r = r;
    endtask

    task automatic do_rd(input int c, input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        addr = 2'(c); we = 1'b0; col_stb = 1'b1;
        exp_q.push_back(model[open_r*4+c]);
        tag_q.push_back(tag);
        @(negedge clk);
        col_stb = 1'b0;
    endtask

    task automatic do_wr(input int c, input logic [7:0] d);
        @(negedge clk);
        while (busy) @(negedge clk);
        addr = 2'(c); we = 1'b1; wd = d; col_stb = 1'b1;
        model[open_r*4+c] = d;
        @(negedge clk);
        col_stb = 1'b0; we = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic l_open(input int r);
        @(negedge clk);
        l_addr = 2'(r); l_row = 1'b1;
        @(negedge clk);
        l_row = 1'b0;
    endtask

    task automatic l_write(input int c, input logic [7:0] d);
        @(negedge clk);
        l_addr = 2'(c); l_we = 1'b1; l_wd = d; l_col = 1'b1;
        @(negedge clk);
        l_col = 1'b0; l_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic l_read(input int c, input logic [7:0] e, input string tag);
        @(negedge clk);
        l_addr = 2'(c); l_col = 1'b1;
        @(negedge clk);
        l_col = 1'b0;
        @(negedge clk);
        check(l_rvalid === 1'b1, tag, l_rvalid, 1);
        check(l_rdata === e, tag, l_rdata, e);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] held;
        int         busy_cnt;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(rvalid === 1'b0, "R1 rvalid", rvalid, 0);
        check(err === 1'b0, "R1 err", err, 0);
        check(busy === 1'b0, "R1 busy", busy, 0);
        check(rdata === 8'h00, "R1 rdata", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: column strobe with no open row
        addr = 2'd1; col_stb = 1'b1;
        @(negedge clk);
        col_stb = 1'b0;
        check(err === 1'b1, "R6 err pulse", err, 1);
        @(negedge clk);
        check(err === 1'b0, "R6 err falls", err, 0);
        check(rvalid === 1'b0, "R6 no rvalid", rvalid, 0);

        // R1: cells start at zero
        do_row(3); do_rd(2, "R1 cell zero"); settle();

        // R3/R2: fill each row, read it back while still open
        for (int r = 0; r < 4; r++) begin
            do_row(r);
            for (int c = 0; c < 4; c++) do_wr(c, 8'((r*4+c)*13 + 7));
            for (int c = 3; c >= 0; c--) do_rd(c, "R3 same-row read");
        end
        settle();

        // R4: reopen each row in a shuffled order
        for (int k = 0; k < 4; k++) begin
            do_row((k*3+1) % 4);
            for (int c = 0; c < 4; c++) do_rd(c, "R4 reopened read");
        end
        settle();

        // R5: strobe the open modified row again
        do_row(2); do_wr(3, 8'h3C); do_row(2); do_rd(3, "R5 same-row reopen");
        settle();

        // R7: writes keep rdata unchanged
        do_row(1); do_rd(2, "R2 read"); settle();
        held = rdata;
        do_wr(0, 8'h77); do_wr(1, 8'h88); settle();
        check(rdata === held, "R7 rdata held", rdata, held);

        // R8: row strobe during the transfer cycle is discarded
        do_row(0);
        do_rd(1, "R2 read");
        addr = 2'd2; row_stb = 1'b1;
        check(busy === 1'b1, "R11 busy in transfer", busy, 1);
        @(negedge clk);
        row_stb = 1'b0;
        do_rd(3, "R8 row stays open");
        settle();

        // R9: long idle stretch with refresh
        busy_cnt = 0;
        repeat (1500) begin
            @(negedge clk);
            if (busy) busy_cnt++;
        end
        check(busy_cnt > 0, "R9 refresh busy seen", busy_cnt, 1);
        do_rd(2, "R9 open row kept");
        for (int r = 0; r < 4; r++) begin
            do_row(r);
            for (int c = 0; c < 4; c++) do_rd(c, "R9 data retained");
        end
        settle();
        check(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);

        // R10: no refresh, data decays
        l_open(1); l_write(2, 8'hA5); l_open(3); l_open(1);
        l_read(2, 8'hA5, "R10 before expiry");
        l_open(3);
        repeat (400) @(negedge clk);
        l_open(1);
        l_read(2, 8'h00, "R10 decayed");
        check(l_err === 1'b0, "R10 no error", l_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule